// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is the processor end of a narrow external bus in which the low address byte and the data byte take turns on the same eight lines. A caller hands it a request made of a 16-bit address, a write-data byte and a direction flag. The block then runs one bus cycle that lasts four reference clocks. During the cycle it drives a slow bus clock, an address strobe, a read/write line and eight dedicated upper-address lines. It steers the shared lines from the low address to the data, and on a read it hands back the byte it captured.

The bus clock runs all the time at one quarter of the reference clock. It is low for the first two reference clocks of each period and high for the last two. The bus cycle always lines up with one full period of the bus clock. While the bus clock is low, the shared lines carry the low address and the strobe marks that phase. An external transparent latch can hold the low address on the falling edge of the strobe. While the bus clock is high, the shared lines carry the write data. On a read the block releases the shared lines during that half so that the addressed device can drive them.

Top module: `mux_bus_master`

## Requirements
- R1: `bus_e` repeats a period of four clock cycles: low for two cycles, then high for two. It keeps toggling when no bus cycle is running.
- R2: For all four clocks of a bus cycle, `bus_hi` equals bits 15..8 of the accepted address.
- R3: In the two bus-clock-low clocks of a bus cycle, `bus_ad_oe` is 1 and `bus_ad_out` equals bits 7..0 of the accepted address.
- R4: `bus_as` is high for exactly one clock, the first clock of a bus cycle, while `bus_e` is low. The low address is still driven when `bus_as` falls.
- R5: On a write (`req_wr`=1), in the two bus-clock-high clocks `bus_ad_oe` is 1 and `bus_ad_out` equals the write byte.
- R6: On a read (`req_wr`=0), `bus_ad_oe` is 0 in the two bus-clock-high clocks, so an external device can drive the lines.
- R7: `bus_rw` is 0 for the whole of a write cycle and 1 at every other time. Read is the high level.
- R8: At the falling edge of `bus_e` that ends a cycle, a read captures `bus_ad_in` into `rdata`. `done` is then high for exactly the one following clock, for reads and for writes alike.
- R9: A request is taken only when `busy` is 0. Once taken, `busy` stays 1 until the cycle ends. A request raised while `busy` is 1 is ignored and starts no cycle. A cycle always begins on the clock right after a falling edge of `bus_e`.
- R10: Outside a bus cycle, `bus_as` is 0 and `bus_ad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, four times the bus clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe, sampled on each rising edge |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Bus address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | A request is held or a bus cycle is running |
| done | output | 1 | One-clock pulse after a cycle ends |
| rdata | output | 8 | Byte captured by the last read |
| bus_e | output | 1 | Bus clock |
| bus_as | output | 1 | Address strobe |
| bus_rw | output | 1 | Read/write line, high = read |
| bus_hi | output | 8 | Upper address lines |
| bus_ad_out | output | 8 | Shared lines, value driven |
| bus_ad_oe | output | 1 | Shared lines, drive enable |
| bus_ad_in | input | 8 | Shared lines, value seen from the bus |

## Verification
The assertions assume that the external device drives the shared lines only while `bus_e` is high and `bus_rw` is high. They also assume that requests arriving while `busy` is high may be dropped. The bench device model follows the first assumption exactly: it holds the low address captured with the strobe and drives a data byte derived from the full address only in that window. Random and directed requests are issued from idle, and on purpose a second request is raised in the middle of a running cycle, where it must have no effect.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_RUN} sq_t;

  // bus clock level for a given reference-clock phase inside one period
  function automatic logic f_e_high(input int unsigned ph, input int unsigned div);
    return ph >= (div / 2);
  endfunction

  // phase on which the strobe is raised
  function automatic logic f_strobe_phase(input int unsigned ph);
    return ph == 0;
  endfunction
endpackage

// File: rtl/mbm_phase.sv
module mbm_phase #(
  parameter int DIV = 4,
  localparam int PH_W = $clog2(DIV)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph,
  output logic            e_lvl,
  output logic            last_ph
);
  import mbm_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ph <= '0;
    else if (last_ph) ph <= '0;
    else              ph <= ph + 1'b1;
  end

  assign last_ph = (ph == PH_W'(DIV - 1));
  assign e_lvl   = f_e_high(32'(ph), DIV);

  AST_E_FALLS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    last_ph |=> !e_lvl); // R1
endmodule

// File: rtl/mbm_seq.sv
module mbm_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              last_ph,
  output logic              run,
  output logic              busy,
  output logic              cyc_end,
  output logic              cur_wr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata
);
  import mbm_pkg::*;

  sq_t st;
  logic take;

  assign take    = req && (st == SQ_IDLE);
  assign run     = (st == SQ_RUN);
  assign busy    = (st != SQ_IDLE);
  assign cyc_end = run && last_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      cur_wr    <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (take) begin
          cur_wr    <= req_wr;
          cur_addr  <= req_addr;
          cur_wdata <= req_wdata;
          st        <= last_ph ? SQ_RUN : SQ_WAIT;
        end
        SQ_WAIT: if (last_ph) st <= SQ_RUN;
        SQ_RUN:  if (last_ph) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_end) |=> busy); // R9
  AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cur_addr) && $stable(cur_wr))); // R9
endmodule

// File: rtl/mbm_pins.sv
module mbm_pins #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DIV    = 4,
  localparam int PH_W  = $clog2(DIV),
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PH_W-1:0]   ph,
  input  logic              e_lvl,
  input  logic              run,
  input  logic              cyc_end,
  input  logic              cur_wr,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic              as_o,
  output logic              rw_o,
  output logic [HI_W-1:0]   hi_o,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  import mbm_pkg::*;

  logic lo_half;
  logic first_ph;

  assign lo_half  = !e_lvl;
  assign first_ph = f_strobe_phase(32'(ph));
  assign as_o     = run && first_ph;
  assign rw_o     = !(run && cur_wr);
  assign hi_o     = cur_addr[ADDR_W-1 -: HI_W];
  assign ad_out   = lo_half ? cur_addr[DATA_W-1:0] : cur_wdata;
  assign ad_oe    = run && (lo_half || cur_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= cyc_end;
      if (cyc_end && !cur_wr) rdata <= ad_in;
    end
  end

  AST_HI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !first_ph) |-> $stable(hi_o)); // R2
  AST_AS_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    as_o |-> (!e_lvl && ad_oe)); // R4
  AST_AS_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    as_o |=> (!as_o && ad_oe && !e_lvl)); // R4
  AST_NO_CONTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (e_lvl && rw_o) |-> !ad_oe); // R6
  AST_RW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !first_ph) |-> $stable(rw_o)); // R7
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cyc_end)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!as_o && !ad_oe && rw_o)); // R10
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DIV    = 4,
  localparam int PH_W  = $clog2(DIV),
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_e,
  output logic              bus_as,
  output logic              bus_rw,
  output logic [HI_W-1:0]   bus_hi,
  output logic [DATA_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [DATA_W-1:0] bus_ad_in
);
  logic [PH_W-1:0]   ph;
  logic              last_ph;
  logic              run;
  logic              cyc_end;
  logic              cur_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  mbm_phase #(.DIV(DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .ph(ph), .e_lvl(bus_e), .last_ph(last_ph)
  );

  mbm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .last_ph(last_ph),
    .run(run), .busy(busy), .cyc_end(cyc_end), .cur_wr(cur_wr),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata)
  );

  mbm_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV(DIV)) u_pins (
    .clk(clk), .rst_n(rst_n), .ph(ph), .e_lvl(bus_e), .run(run),
    .cyc_end(cyc_end), .cur_wr(cur_wr), .cur_addr(cur_addr),
    .cur_wdata(cur_wdata), .ad_in(bus_ad_in), .as_o(bus_as),
    .rw_o(bus_rw), .hi_o(bus_hi), .ad_out(bus_ad_out), .ad_oe(bus_ad_oe),
    .done(done), .rdata(rdata)
  );
endmodule

// File: tb/test_mux_bus_master.sv
module test_mux_bus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done, bus_e, bus_as, bus_rw, bus_ad_oe;
  logic [7:0]  rdata, bus_hi, bus_ad_out, bus_ad_in;
  logic [7:0]  lat_lo = '0;
  int checks = 0;
  int errs = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mux_bus_master i_mux_bus_master (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .bus_e(bus_e), .bus_as(bus_as), .bus_rw(bus_rw),
    .bus_hi(bus_hi), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_ad_in(bus_ad_in)
  );

  function automatic logic [7:0] dev_byte(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  // external device: latch low address with the strobe, drive only in read data half
  always @(posedge clk) if (bus_as) lat_lo <= bus_ad_out;
  assign bus_ad_in = (bus_e && bus_rw) ? dev_byte({bus_hi, lat_lo}) : 8'h00;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic txn(input bit wr, input logic [15:0] a, input logic [7:0] wd);
    bit prev_e;
    int n;
    @(negedge clk);
    chk(busy == 0, "R9 idle before request", busy, 0);
    req = 1; req_wr = wr; req_addr = a; req_wdata = wd;
    prev_e = bus_e;
    @(negedge clk);
    req = 0;
    chk(busy == 1, "R9 taken", busy, 1);
    n = 0;
    while (!bus_as && n < 12) begin
      chk(bus_ad_oe == 0, "R10 quiet while waiting", bus_ad_oe, 0);
      prev_e = bus_e;
      @(negedge clk);
      n++;
    end
    // first clock of the cycle
    chk(bus_as == 1, "R4 strobe seen", bus_as, 1);
    chk(prev_e == 1 && bus_e == 0, "R9 start at E fall", {prev_e, bus_e}, 2'b10);
    chk(bus_hi == a[15:8], "R2 hi ph0", bus_hi, a[15:8]);
    chk(bus_ad_oe && bus_ad_out == a[7:0], "R3 lo ph0", {bus_ad_oe, bus_ad_out}, {1'b1, a[7:0]});
    chk(bus_rw == !wr, "R7 rw ph0", bus_rw, !wr);
    @(negedge clk);
    chk(bus_as == 0 && bus_e == 0, "R4 strobe one clock", {bus_as, bus_e}, 0);
    chk(bus_ad_oe && bus_ad_out == a[7:0], "R3 lo ph1", {bus_ad_oe, bus_ad_out}, {1'b1, a[7:0]});
    // request during a running cycle must be dropped
    req = 1; req_wr = 1; req_addr = ~a; req_wdata = ~wd;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      req = 0;
      chk(bus_e == 1, "R1 high half", bus_e, 1);
      chk(bus_hi == a[15:8], "R2 hi high half", bus_hi, a[15:8]);
      chk(bus_rw == !wr, "R7 rw high half", bus_rw, !wr);
      if (wr) chk(bus_ad_oe && bus_ad_out == wd, "R5 write data", {bus_ad_oe, bus_ad_out}, {1'b1, wd});
      else    chk(bus_ad_oe == 0, "R6 released on read", bus_ad_oe, 0);
      chk(done == 0, "R8 no early done", done, 0);
    end
    @(negedge clk);
    chk(done == 1, "R8 done pulse", done, 1);
    chk(busy == 0, "R9 busy clears", busy, 0);
    if (!wr) chk(rdata == dev_byte(a), "R8 read data", rdata, dev_byte(a));
    chk(bus_as == 0 && bus_ad_oe == 0 && bus_rw == 1, "R10 idle pins", {bus_as, bus_ad_oe, bus_rw}, 3'b001);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(done == 0 && bus_as == 0 && busy == 0, "R9 dropped request", {done, bus_as, busy}, 0);
    end
  endtask

  initial begin
    #(8 * 100000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  initial begin
    bit pe;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && bus_as == 0 && bus_ad_oe == 0 && bus_rw == 1,
        "R10 reset state", {busy, done, bus_as, bus_ad_oe, bus_rw}, 5'b00001);
    // R1: find a falling edge, then check the period shape
    pe = bus_e;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (pe && !bus_e) break;
      pe = bus_e;
    end
    for (int k = 1; k < 9; k++) begin
      @(negedge clk);
      chk(bus_e == ((k % 4) >= 2), "R1 E shape", bus_e, ((k % 4) >= 2));
    end
    txn(0, 16'h0000, 8'h00);
    txn(1, 16'hFFFF, 8'hFF);
    txn(0, 16'h4000, 8'h00);
    txn(1, 16'h5A3C, 8'h81);
    txn(0, 16'hFFFF, 8'h00);
    for (int t = 0; t < 30; t++) begin
      logic [15:0] ra;
      logic [7:0]  rw;
      bit wr;
      ra = 16'($urandom);
      rw = 8'($urandom);
      wr = 1'($urandom);
      repeat ($urandom % 4) @(negedge clk);
      txn(wr, ra, rw);
    end
    report();
  end
endmodule